// File: doc/BRIEF.md
# UART Control Register Bank with Enhanced-Bit Write Lock

This block holds the control registers of a 16550-style UART: interrupt enable, interrupt status control, FIFO control and modem control, plus a feature register. Some bit positions in the first four registers carry "enhanced" functions. Bit 4 of the feature register is an unlock bit, and it decides whether those positions accept writes. When the unlock bit is 0, the enhanced bits keep whatever they last held. Software written for the plain 16550 then cannot disturb settings that newer software made earlier. Legacy bit positions accept writes at all times.

The bank sits on a simple synchronous bus. A write strobe, a 3-bit address and a separate feature-register select drive it. Reading is combinational and has no side effects. Every register value is also driven on its own output, so the serial engine and the interrupt logic can use the values directly.

Top module: `uart_enh_lock_regs`

## Requirements
- R1: A synchronous, active-high reset clears all five registers to 0x00, so after reset every enhanced position reads 0.
- R2: With `ext_sel`=1, a write stores all 8 data bits in the feature register at any address, whatever its current value.
- R3: With feature bit 4 = 1, a write to interrupt enable (addr 1), status control (addr 2), FIFO control (addr 3) or modem control (addr 4), with `ext_sel`=0, stores all 8 data bits.
- R4: With feature bit 4 = 0, a write leaves the enhanced positions unchanged. These are interrupt enable bits 7:4 (mask 0xF0), status control bits 5:4 (0x30), FIFO control bits 5:4 (0x30) and modem control bits 7, 6, 5 and 2 (0xE4).
- R5: The non-enhanced positions of those four registers take the written data whatever the state of feature bit 4.
- R6: `rd_data` returns, in the same cycle, the register selected by `ext_sel` and `addr` (feature register when `ext_sel`=1, else addr 1 to 4 as in R3). Reading changes no register.
- R7: With `ext_sel`=0, addresses 0, 5, 6 and 7 read 0x00, and a write to them changes no register.
- R8: A write takes effect on the clock edge where `wr_en` is sampled high. The register outputs and the readback show the new value from then on, and they hold steady while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| ext_sel | input | 1 | Selects the feature register |
| addr | input | 3 | Register address when ext_sel is 0 |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational readback |
| ier_q | output | 8 | Interrupt enable register |
| isr_q | output | 8 | Interrupt status control register |
| fcr_q | output | 8 | FIFO control register |
| mcr_q | output | 8 | Modem control register |
| efr_q | output | 8 | Feature register, bit 4 unlocks enhanced bits |

## Verification
A write sampled at a rising edge is visible on the register outputs and through `rd_data` right after that edge. The bench therefore drives each operation at a falling edge and checks all five outputs at the next falling edge. Readback has no register in its path, so the bench sets `addr` and `ext_sel` with the strobe low and samples `rd_data` a nanosecond later. A second sample confirms that the read left every register unchanged. Random writes toggle the unlock bit often, so locked and unlocked writes reach every register, and a bench model tracks the expected contents.

// File: rtl/uart_enh_lock_regs.sv
module uart_enh_lock_regs #(
  parameter logic [7:0] IER_ENH = 8'hF0,
  parameter logic [7:0] ISR_ENH = 8'h30,
  parameter logic [7:0] FCR_ENH = 8'h30,
  parameter logic [7:0] MCR_ENH = 8'hE4,
  parameter int         UNLOCK_BIT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       ext_sel,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [7:0] ier_q,
  output logic [7:0] isr_q,
  output logic [7:0] fcr_q,
  output logic [7:0] mcr_q,
  output logic [7:0] efr_q
);

  logic unlocked;
  logic sel_ier, sel_isr, sel_fcr, sel_mcr;

  assign unlocked = efr_q[UNLOCK_BIT];
  assign sel_ier  = !ext_sel && addr == 3'd1;
  assign sel_isr  = !ext_sel && addr == 3'd2;
  assign sel_fcr  = !ext_sel && addr == 3'd3;
  assign sel_mcr  = !ext_sel && addr == 3'd4;

  function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] nw,
                                       input logic [7:0] enh, input logic open);
    logic [7:0] keep;
    keep  = open ? 8'h00 : enh;
    merge = (nw & ~keep) | (old & keep);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q <= '0;
      isr_q <= '0;
      fcr_q <= '0;
      mcr_q <= '0;
      efr_q <= '0;
    end else if (wr_en) begin
      if (ext_sel) efr_q <= wr_data;
      if (sel_ier) ier_q <= merge(ier_q, wr_data, IER_ENH, unlocked);
      if (sel_isr) isr_q <= merge(isr_q, wr_data, ISR_ENH, unlocked);
      if (sel_fcr) fcr_q <= merge(fcr_q, wr_data, FCR_ENH, unlocked);
      if (sel_mcr) mcr_q <= merge(mcr_q, wr_data, MCR_ENH, unlocked);
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (ext_sel)      rd_data = efr_q;
    else if (sel_ier) rd_data = ier_q;
    else if (sel_isr) rd_data = isr_q;
    else if (sel_fcr) rd_data = fcr_q;
    else if (sel_mcr) rd_data = mcr_q;
  end

  // R4
  ier_enh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && sel_ier && !unlocked |=> (ier_q & IER_ENH) == ($past(ier_q) & IER_ENH));

  // R4
  mcr_enh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && sel_mcr && !unlocked |=> (mcr_q & MCR_ENH) == ($past(mcr_q) & MCR_ENH));

  // R3
  fcr_open_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && sel_fcr && unlocked |=> fcr_q == $past(wr_data));

  // R5
  isr_legacy_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && sel_isr |=> (isr_q & ~ISR_ENH) == ($past(wr_data) & ~ISR_ENH));

  // R2
  efr_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && ext_sel |=> efr_q == $past(wr_data));

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ier_q) && $stable(isr_q) && $stable(fcr_q) && $stable(mcr_q) && $stable(efr_q));

endmodule

// File: tb/tb_uart_enh_lock_regs.sv
module tb_uart_enh_lock_regs;
  logic clk = 0, rst = 1, wr_en = 0, ext_sel = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, ier_q, isr_q, fcr_q, mcr_q, efr_q;
  int total = 0, bad = 0;
  logic [7:0] m_reg [0:4];
  logic [7:0] enh [0:3];

  uart_enh_lock_regs dut (.clk, .rst, .wr_en, .ext_sel, .addr, .wr_data,
    .rd_data, .ier_q, .isr_q, .fcr_q, .mcr_q, .efr_q);

  always #4 clk = ~clk;

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_rd(input logic e, input logic [2:0] a);
    if (e) return m_reg[4];
    if (a >= 3'd1 && a <= 3'd4) return m_reg[a - 1];
    return 8'h00;
  endfunction

  function automatic logic [7:0] merge_m(input logic [7:0] o, input logic [7:0] n,
                                         input logic [7:0] k);
    return (n & ~k) | (o & k);
  endfunction

  task automatic check_all(input string req);
    chk(req, ier_q, m_reg[0]);
    chk(req, isr_q, m_reg[1]);
    chk(req, fcr_q, m_reg[2]);
    chk(req, mcr_q, m_reg[3]);
    chk(req, efr_q, m_reg[4]);
  endtask

  task automatic wr(input logic e, input logic [2:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_en = 1; ext_sel = e; addr = a; wr_data = d;
    if (e) m_reg[4] = d;
    else if (a >= 3'd1 && a <= 3'd4)
      m_reg[a - 1] = merge_m(m_reg[a - 1], d, m_reg[4][4] ? 8'h00 : enh[a - 1]);
    @(negedge clk);
    wr_en = 0;
    check_all(req);
  endtask

  task automatic rd(input logic e, input logic [2:0] a, input string req);
    @(negedge clk);
    wr_en = 0; ext_sel = e; addr = a;
    #1 chk(req, rd_data, expect_rd(e, a));
    @(negedge clk);
    chk(req, rd_data, expect_rd(e, a));
    check_all("R6 read side effect");
  endtask

  initial begin
    void'($urandom(32'd1234));
    enh[0] = 8'hF0; enh[1] = 8'h30; enh[2] = 8'h30; enh[3] = 8'hE4;
    for (int i = 0; i < 5; i++) m_reg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    check_all("R1 reset");
    for (int a = 1; a <= 4; a++) rd(0, 3'(a), "R1 reset readback");

    wr(0, 3'd1, 8'hFF, "R4 locked ier");
    wr(0, 3'd4, 8'hFF, "R4 locked mcr");
    rd(0, 3'd4, "R5 legacy mcr");
    wr(1, 3'd0, 8'h10, "R2 unlock");
    wr(0, 3'd1, 8'hA5, "R3 open ier");
    wr(0, 3'd2, 8'hFF, "R3 open isr");
    wr(0, 3'd3, 8'h3C, "R3 open fcr");
    wr(0, 3'd4, 8'hE4, "R3 open mcr");
    wr(1, 3'd7, 8'hEF, "R2 lock");
    wr(0, 3'd1, 8'h0F, "R4 locked ier keep");
    wr(0, 3'd2, 8'h00, "R5 legacy isr");
    wr(0, 3'd3, 8'h00, "R4 locked fcr keep");
    wr(0, 3'd4, 8'h1B, "R5 legacy mcr");
    for (int a = 0; a < 8; a += 5) begin
      wr(0, 3'(a), 8'h5A, "R7 unmapped write");
      rd(0, 3'(a), "R7 unmapped read");
    end
    wr(0, 3'd6, 8'hFF, "R7 unmapped write");
    rd(0, 3'd7, "R7 unmapped read");
    rd(1, 3'd3, "R6 efr read");

    @(negedge clk);
    ext_sel = 0; addr = 3'd1; wr_data = 8'h77;
    repeat (3) @(negedge clk);
    check_all("R8 idle hold");

    for (int i = 0; i < 3000; i++) begin
      logic e;
      logic [2:0] a;
      logic [7:0] d;
      e = ($urandom % 6) == 0;
      a = 3'($urandom);
      d = 8'($urandom);
      if ($urandom % 4 == 0) rd(e, a, "R6 random read");
      else wr(e, a, d, e ? "R2 random" : (m_reg[4][4] ? "R3 random" : "R4 random"));
    end

    @(negedge clk);
    rst = 1;
    for (int i = 0; i < 5; i++) m_reg[i] = 8'h00;
    @(negedge clk);
    rst = 0;
    check_all("R1 second reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule